// File: doc/BRIEF.md
# SPI Register Access Target

This block is the serial front end of a peripheral whose registers are reached over a four-wire SPI link. An external controller opens a frame by pulling chip select low, clocks in a 32-bit header and then a series of 32-bit data words, and closes the frame by releasing chip select. The block turns each frame into accesses on a simple internal register bus: reads are fetched word by word and shifted back to the controller, and writes are held in a small staging buffer.

All pins are sampled with the block's own system clock through short synchronisers, so the SPI clock must run several times slower than the system clock. When chip select is released the block judges the whole frame. Only a frame that is word-aligned, carries a known opcode and delivers exactly the number of data words its header promised lets its staged writes reach the register bus. A frame that fails any test is dropped without a trace, and the error is reported both on a status pin and in the status byte of the next header.

Top module: `spi_regif`

## Requirements
- R1: The link runs in SPI mode 0. The clock idles low, MOSI is taken on each rising SCLK edge, MISO changes only after a falling SCLK edge or at the start of a frame, and every word is carried most significant bit first.
- R2: The first word of a frame is the header. Bits 31:24 hold the opcode (0x41 read, 0x61 write), bits 23:8 a 16-bit byte address and bits 7:0 the count of data words that follow.
- R3: In a read frame, data word k returned on MISO is the register at header address + 4*k, sent MSB first, for k from 0 up to the length minus 1.
- R4: In a valid write frame, after chip select rises, the data words are written to the register bus in the order they were received, to header address + 4*k, one word per system clock and never while chip select is low.
- R5: A frame whose bit count is not a whole multiple of 32 is an error and none of its data is written.
- R6: A frame whose number of data words differs from the header length is an error and none of its data is written; a frame with no complete header is also an error.
- R7: An opcode other than 0x41 or 0x61, a length of 0, or a write length larger than the staging buffer (8 words by default) makes the frame an error and none of its data is written.
- R8: While the header is shifted in, MISO returns a status byte followed by 24 zero bits; bit 0 of the status byte (bit 24 of the word) and the spi_err pin both show whether the most recently closed frame was an error, and both change only when a frame closes.
- R9: After reset spi_err and MISO are low and the register bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the controller |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| reg_addr | output | 16 | Register bus byte address |
| reg_wr_en | output | 1 | Register bus write strobe |
| reg_wr_data | output | 32 | Register bus write data |
| reg_rd_en | output | 1 | Register bus read strobe; data is taken in the same cycle |
| reg_rd_data | input | 32 | Register bus read data |
| spi_err | output | 1 | Result of the most recently closed frame, high when it was malformed |

## Verification
Frames are drawn at random between single and multi-word reads and writes at random addresses, mixed with directed frames that break exactly one rule each: an over-long write, a trailing partial word, one word short, extra words, an unknown opcode, a zero length and a chip-select pulse with no clock. A write followed by a read of the same range tells correct address stepping and word order apart from a bus that merely moves data, while the shadow register image compared after every frame separates a frame that was dropped whole from one that leaked some of its writes. The status byte of each header is compared against the verdict of the frame before it, which shows that the error indication both sets and clears.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;
    localparam int OPC_W  = 8;
    localparam int ADDR_STEP = WORD_W / 8;

    localparam logic [OPC_W-1:0] OPC_READ  = 8'h41;
    localparam logic [OPC_W-1:0] OPC_WRITE = 8'h61;

    // Header word as it arrives, most significant field first.
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } hdr_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_t;

    typedef struct packed {
        logic [6:0] rsvd;
        logic       err;
    } status_t;

    function automatic acc_t decode_acc(input logic [OPC_W-1:0] opc);
        if (opc == OPC_READ)  return ACC_READ;
        if (opc == OPC_WRITE) return ACC_WRITE;
        return ACC_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic err);
        status_t st;
        st.rsvd = '0;
        st.err  = err;
        return {st, {(WORD_W-8){1'b0}}};
    endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic frame_start,
    output logic frame_end,
    output logic cs_active,
    output logic mosi_bit
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE_PINS = 3'b100;

    logic [NSIG-1:0] pins;
    logic [STAGES-1:0][NSIG-1:0] chain;
    logic [NSIG-1:0] last;
    logic [1:0] prev;

    assign pins = {cs_n, sclk, mosi};
    assign last = chain[STAGES-1];

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= IDLE_PINS;
                else     chain <= pins;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{IDLE_PINS}};
                else     chain <= {chain[STAGES-2:0], pins};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= IDLE_PINS[2:1];
        else     prev <= last[2:1];
    end

    assign cs_active   = ~last[2];
    assign sclk_rise   = last[1] & ~prev[0] & cs_active;
    assign sclk_fall   = ~last[1] & prev[0] & cs_active;
    assign frame_start = ~last[2] & prev[1];
    assign frame_end   = last[2] & ~prev[1];
    assign mosi_bit    = last[0];

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic [WORD_W-1:0] start_word,
    input  logic [WORD_W-1:0] load_word,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output logic              aligned,
    output logic              miso
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;
    logic              load_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
            word_done <= 1'b0;
            rx_word   <= '0;
        end else begin
            word_done <= 1'b0;
            if (frame_start) begin
                bit_cnt   <= '0;
                load_pend <= 1'b0;
                tx_sh     <= start_word;
            end else begin
                if (sclk_rise) begin
                    rx_sh   <= {rx_sh[WORD_W-2:0], mosi_bit};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        word_done <= 1'b1;
                        rx_word   <= {rx_sh[WORD_W-2:0], mosi_bit};
                        load_pend <= 1'b1;
                    end
                end
                if (sclk_fall) begin
                    if (load_pend) begin
                        tx_sh     <= load_word;
                        load_pend <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign aligned = (bit_cnt == '0);
    assign miso    = tx_sh[WORD_W-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_regif_pkg::*;
#(
    parameter int BUF_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              word_done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              aligned,
    input  logic [WORD_W-1:0] reg_rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] tx_next,
    output logic              push_en,
    output logic [$clog2(BUF_WORDS)-1:0] push_idx,
    output logic [WORD_W-1:0] push_data,
    output logic              commit_go,
    output logic [ADDR_W-1:0] commit_base,
    output logic [LEN_W-1:0]  commit_cnt,
    output logic              err_flag
);
    localparam int IDX_W = $clog2(BUF_WORDS);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_WORDS);

    hdr_t             hdr;
    hdr_t             hdr_in;
    acc_t             acc;
    acc_t             acc_in;
    logic             hdr_seen;
    logic [CNT_W-1:0] n_data;
    logic [CNT_W-1:0] len_ext;
    logic             frame_bad;

    assign hdr_in  = hdr_t'(rx_word);
    assign acc_in  = decode_acc(hdr_in.opc);
    assign len_ext = {1'b0, hdr.len};

    always_comb begin
        frame_bad = 1'b0;
        if (!hdr_seen)                                frame_bad = 1'b1;
        if (!aligned)                                 frame_bad = 1'b1;
        if (acc == ACC_NONE)                          frame_bad = 1'b1;
        if (hdr.len == '0)                            frame_bad = 1'b1;
        if (acc == ACC_WRITE && len_ext > BUF_LIM)    frame_bad = 1'b1;
        if (n_data != len_ext)                        frame_bad = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr         <= '0;
            acc         <= ACC_NONE;
            hdr_seen    <= 1'b0;
            n_data      <= '0;
            rd_en       <= 1'b0;
            rd_addr     <= '0;
            tx_next     <= '0;
            push_en     <= 1'b0;
            push_idx    <= '0;
            push_data   <= '0;
            commit_go   <= 1'b0;
            commit_base <= '0;
            commit_cnt  <= '0;
            err_flag    <= 1'b0;
        end else begin
            rd_en     <= 1'b0;
            push_en   <= 1'b0;
            commit_go <= 1'b0;
            if (frame_start) begin
                hdr_seen <= 1'b0;
                acc      <= ACC_NONE;
                n_data   <= '0;
                tx_next  <= '0;
            end else if (word_done) begin
                tx_next <= '0;
                if (!hdr_seen) begin
                    hdr      <= hdr_in;
                    acc      <= acc_in;
                    hdr_seen <= 1'b1;
                    if (acc_in == ACC_READ && hdr_in.len != '0) begin
                        rd_en   <= 1'b1;
                        rd_addr <= hdr_in.addr;
                    end
                end else begin
                    if (n_data != CNT_MAX) n_data <= n_data + 1'b1;
                    if (acc == ACC_WRITE && n_data < BUF_LIM) begin
                        push_en   <= 1'b1;
                        push_idx  <= n_data[IDX_W-1:0];
                        push_data <= rx_word;
                    end
                    if (acc == ACC_READ && (n_data + 1'b1) < len_ext) begin
                        rd_en   <= 1'b1;
                        rd_addr <= rd_addr + ADDR_W'(ADDR_STEP);
                    end
                end
            end else if (frame_end) begin
                err_flag <= frame_bad;
                if (!frame_bad && acc == ACC_WRITE) begin
                    commit_go   <= 1'b1;
                    commit_base <= hdr.addr;
                    commit_cnt  <= hdr.len;
                end
            end
            // Read data is taken in the cycle the strobe is high.
            if (rd_en) tx_next <= reg_rd_data;
        end
    end

endmodule

// File: rtl/spi_wr_stage.sv
module spi_wr_stage
    import spi_regif_pkg::*;
#(
    parameter int BUF_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [$clog2(BUF_WORDS)-1:0] push_idx,
    input  logic [WORD_W-1:0] push_data,
    input  logic              commit_go,
    input  logic [ADDR_W-1:0] commit_base,
    input  logic [LEN_W-1:0]  commit_cnt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    localparam int IDX_W = $clog2(BUF_WORDS);

    logic [WORD_W-1:0] stage_q [BUF_WORDS];
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [ADDR_W-1:0] base;
    logic              busy;

    always_ff @(posedge clk) begin
        for (int i = 0; i < BUF_WORDS; i++) begin
            if (push_en && push_idx == IDX_W'(i)) stage_q[i] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
            base     <= '0;
        end else if (commit_go) begin
            busy     <= 1'b1;
            idx      <= '0;
            last_idx <= IDX_W'(commit_cnt - 1'b1);
            base     <= commit_base;
        end else if (busy) begin
            if (idx == last_idx) busy <= 1'b0;
            else                 idx  <= idx + 1'b1;
        end
    end

    assign wr_en   = busy;
    assign wr_addr = base + (ADDR_W'(idx) << $clog2(ADDR_STEP));
    assign wr_data = stage_q[idx];

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int BUF_WORDS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [15:0] reg_addr,
    output logic        reg_wr_en,
    output logic [31:0] reg_wr_data,
    output logic        reg_rd_en,
    input  logic [31:0] reg_rd_data,
    output logic        spi_err
);
    localparam int IDX_W = $clog2(BUF_WORDS);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              frame_start;
    logic              frame_end;
    logic              cs_active;
    logic              mosi_bit;
    logic              word_done;
    logic [WORD_W-1:0] rx_word;
    logic              aligned;
    logic [WORD_W-1:0] tx_next;
    logic [WORD_W-1:0] hdr_reply;
    logic [ADDR_W-1:0] rd_addr;
    logic              push_en;
    logic [IDX_W-1:0]  push_idx;
    logic [WORD_W-1:0] push_data;
    logic              commit_go;
    logic [ADDR_W-1:0] commit_base;
    logic [LEN_W-1:0]  commit_cnt;
    logic [ADDR_W-1:0] wr_addr;

    spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .frame_start(frame_start), .frame_end(frame_end),
        .cs_active(cs_active), .mosi_bit(mosi_bit)
    );

    assign hdr_reply = status_word(spi_err);

    spi_shifter u_shift (
        .clk(clk), .rst(rst),
        .frame_start(frame_start), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_bit(mosi_bit), .start_word(hdr_reply), .load_word(tx_next),
        .word_done(word_done), .rx_word(rx_word), .aligned(aligned),
        .miso(spi_miso)
    );

    spi_frame_ctrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
        .clk(clk), .rst(rst),
        .frame_start(frame_start), .frame_end(frame_end),
        .word_done(word_done), .rx_word(rx_word), .aligned(aligned),
        .reg_rd_data(reg_rd_data),
        .rd_en(reg_rd_en), .rd_addr(rd_addr), .tx_next(tx_next),
        .push_en(push_en), .push_idx(push_idx), .push_data(push_data),
        .commit_go(commit_go), .commit_base(commit_base), .commit_cnt(commit_cnt),
        .err_flag(spi_err)
    );

    spi_wr_stage #(.BUF_WORDS(BUF_WORDS)) u_stage (
        .clk(clk), .rst(rst),
        .push_en(push_en), .push_idx(push_idx), .push_data(push_data),
        .commit_go(commit_go), .commit_base(commit_base), .commit_cnt(commit_cnt),
        .wr_en(reg_wr_en), .wr_addr(wr_addr), .wr_data(reg_wr_data)
    );

    // Reads happen only inside a frame, commits only between frames.
    assign reg_addr = reg_wr_en ? wr_addr : rd_addr;

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_active,
    input logic        frame_start,
    input logic        frame_end,
    input logic        sclk_fall,
    input logic        spi_miso,
    input logic        spi_err,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [15:0] reg_addr
);
    // R1: MISO moves only on a falling SCLK edge or at frame start
    p_miso_edge_r1: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !frame_start) |=> $stable(spi_miso));

    // R3: register reads are issued only while a frame is open
    p_rd_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> cs_active);

    // R4: commits never overlap an open frame or a read
    p_wr_idle_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (!cs_active && !reg_rd_en));

    // R4: consecutive committed words step the address by one word
    p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && $past(reg_wr_en)) |-> (reg_addr == $past(reg_addr) + 16'd4));

    // R5: no write follows a frame judged to be in error
    p_wr_clean_r5: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> !spi_err);

    // R8: the error pin changes only right after a frame closes
    p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(spi_err));

endmodule

bind spi_regif spi_regif_chk u_chk (
    .clk(clk), .rst(rst),
    .cs_active(cs_active), .frame_start(frame_start), .frame_end(frame_end),
    .sclk_fall(sclk_fall), .spi_miso(spi_miso), .spi_err(spi_err),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr)
);

// File: tb/sim_spi_regif.sv
`timescale 1ns/1ps
module sim_spi_regif;

    localparam int HP = 6;          // SCLK half period in system clocks
    localparam int BUFW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic        reg_rd_en;
    logic [31:0] reg_rd_data;
    logic        spi_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] dut_mem [256];
    logic [31:0] exp_mem [256];
    logic [31:0] tx_w [16];
    logic [31:0] rx_w [16];
    bit          prev_err = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spi_regif u0 (
        .clk(clk), .rst(rst),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data), .spi_err(spi_err)
    );

    // Register file behind the bus: combinational read, clocked write.
    assign reg_rd_data = dut_mem[reg_addr[9:2]];
    always @(posedge clk) if (reg_wr_en) dut_mem[reg_addr[9:2]] <= reg_wr_data;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic bit frame_bad_f(input logic [7:0] op, input logic [7:0] len,
                                       input int nbits);
        if (nbits < 32 || (nbits % 32) != 0) return 1'b1;
        if (op != 8'h41 && op != 8'h61) return 1'b1;
        if (len == 8'd0) return 1'b1;
        if (op == 8'h61 && len > BUFW) return 1'b1;
        return (nbits / 32 - 1) != int'(len);
    endfunction

    // Mode 0 controller: MOSI set while SCLK low, MISO taken at the rising edge (R1).
    task automatic spi_xfer(input int nbits);
        for (int i = 0; i < 16; i++) rx_w[i] = '0;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int b = 0; b < nbits; b++) begin
            mosi = tx_w[b/32][31 - (b % 32)];
            wait_clk(HP);
            sclk = 1'b1;
            rx_w[b/32][31 - (b % 32)] = miso;
            wait_clk(HP);
            sclk = 1'b0;
        end
        wait_clk(HP);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(24);
    endtask

    // Header layout (R2): {opcode, address, length}.
    task automatic run_frame(input logic [7:0] op, input logic [15:0] addr,
                             input logic [7:0] len, input int ndata, input int extra,
                             input string req);
        int  nbits;
        bit  bad;
        int  mism;
        logic [7:0] mi;
        tx_w[0] = {op, addr, len};
        for (int k = 1; k < 16; k++) tx_w[k] = $urandom;
        nbits = 32 * (1 + ndata) + extra;
        bad = frame_bad_f(op, len, nbits);
        spi_xfer(nbits);
        if (nbits >= 32)
            chk(rx_w[0] == {7'd0, prev_err, 24'd0}, "R8 status byte", rx_w[0],
                {7'd0, prev_err, 24'd0});
        if (!bad && op == 8'h41) begin
            for (int k = 0; k < int'(len); k++) begin
                mi = addr[9:2] + 8'(k);
                chk(rx_w[k+1] == exp_mem[mi], "R1 R3 read word", rx_w[k+1], exp_mem[mi]);
            end
        end
        chk(spi_err == bad, {req, " error pin"}, {31'd0, spi_err}, {31'd0, bad});
        if (!bad && op == 8'h61) begin
            for (int k = 0; k < int'(len); k++) begin
                mi = addr[9:2] + 8'(k);
                exp_mem[mi] = tx_w[k+1];
            end
        end
        mism = 0;
        for (int i = 0; i < 256; i++) if (dut_mem[i] !== exp_mem[i]) mism++;
        chk(mism == 0, {req, " register image"}, 32'(mism), 32'd0);
        prev_err = bad;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  len;
        logic [15:0] addr;
        int          r;
        void'($urandom(32'd7001));
        for (int i = 0; i < 256; i++) begin
            dut_mem[i] = 32'(i) * 32'h01010101 ^ 32'hA5000000;
            exp_mem[i] = 32'(i) * 32'h01010101 ^ 32'hA5000000;
        end
        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);
        // R9: idle after reset
        chk(spi_err == 1'b0, "R9 error pin", {31'd0, spi_err}, 32'd0);
        chk(miso == 1'b0, "R9 miso", {31'd0, miso}, 32'd0);
        chk(!reg_wr_en && !reg_rd_en, "R9 bus idle", {30'd0, reg_wr_en, reg_rd_en}, 32'd0);

        run_frame(8'h61, 16'h0010, 8'd1, 1, 0, "R2 R4 single write");
        run_frame(8'h41, 16'h0010, 8'd1, 1, 0, "R3 single read");
        run_frame(8'h61, 16'h0100, 8'd8, 8, 0, "R4 burst write");
        run_frame(8'h41, 16'h0100, 8'd8, 8, 0, "R3 burst read");
        run_frame(8'h61, 16'h0200, 8'd9, 9, 0, "R7 over buffer");
        run_frame(8'h41, 16'h0100, 8'd2, 2, 0, "R8 clear after error");
        run_frame(8'h61, 16'h0300, 8'd1, 1, 8, "R5 partial word");
        run_frame(8'h61, 16'h0300, 8'd2, 1, 0, "R6 short frame");
        run_frame(8'h61, 16'h0300, 8'd1, 3, 0, "R6 long frame");
        run_frame(8'h55, 16'h0300, 8'd1, 1, 0, "R7 unknown opcode");
        run_frame(8'h41, 16'h0300, 8'd0, 0, 0, "R7 zero length");
        run_frame(8'h61, 16'h0300, 8'd1, -1, 0, "R6 empty frame");
        run_frame(8'h61, 16'hFFFC, 8'd2, 2, 0, "R4 address wrap");

        for (int n = 0; n < 30; n++) begin
            r    = int'($urandom % 10);
            len  = 8'(1 + ($urandom % BUFW));
            addr = 16'($urandom) & 16'hFFFC;
            if (r < 4)       run_frame(8'h41, addr, len, int'(len), 0, "R3 random read");
            else if (r < 8)  run_frame(8'h61, addr, len, int'(len), 0, "R4 random write");
            else if (r == 8) run_frame(8'h61, addr, len, int'(len) + 1, 0, "R6 random count");
            else             run_frame(8'h61, addr, len, int'(len), int'(1 + $urandom % 31),
                                       "R5 random bits");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule